// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

The block watches one or more asynchronous input pins and stamps each of their transitions with the value of a shared free-running counter. Every channel has two stamp registers, one refreshed by rising transitions and one by falling transitions. Each register has its own pending flag, sticky overrun bit and clear strobe. A per-channel configuration word chooses which pending flags reach the channel interrupt line. It also chooses which stamps are handed to an external DMA engine through a request/acknowledge pair.

Each pin passes through a two-flop synchronizer and an edge detector. The stamp therefore holds the counter value two cycles after the pin moved. The DMA side of each channel is a small sequencer with four states. IDLE means nothing is offered. SINGLE offers one stamp in rising-only or falling-only mode. FIRST and SECOND offer the two halves of a pair in both-edges mode. The transitions are:
- IDLE to SINGLE on the selected edge.
- IDLE to FIRST on the closing edge of an armed pair.
- SINGLE to IDLE on acknowledge.
- FIRST to SECOND on acknowledge.
- SECOND to IDLE on acknowledge.
- Any state to IDLE when the channel is disabled.

In both-edges mode the rising-first control picks the order. When it is set, a rising edge arms the pair and the next falling edge launches it, rising stamp first. When it is clear, the roles swap.

Top module: `cap_unit`

## Requirements
- R1: A pin transition driven just after one clock edge is latched at the third following rising clock edge. The stored value equals the counter two cycles after the transition, and the flag is still clear after only two edges.
- R2: A rising transition on an enabled channel loads the rising stamp register and sets the rising flag. A falling transition does the same with the falling register and flag. Other channels are untouched.
- R3: An edge that arrives while its flag is set overwrites the stamp and sets the sticky overrun bit. The clear strobe clears both the flag and the overrun bit. An edge that coincides with its clear strobe leaves the flag set, the overrun bit clear and the new stamp stored.
- R4: The interrupt line is (rising flag AND configuration bit 0) OR (falling flag AND configuration bit 8).
- R5: Configuration bits 2:1 select DMA: 0 = none, 1 = rising stamps, 2 = falling stamps, 3 = both. With code 0 no request is ever raised.
- R6: In a single-edge mode the selected edge raises a request that carries that edge's stamp. The request and its data stay stable until acknowledged. Edges that arrive while it is pending raise no further request. The rising-first control has no effect in these modes.
- R7: In both-edges mode a pair is offered only after an opening edge followed by a closing edge, and the FIRST word is the opening stamp. With rising-first set the order is rising then falling; with it clear the order is falling then rising. A closing edge with no prior opening edge offers nothing.
- R8: A disabled channel ignores pin edges: flags, stamps and overrun bits keep their values, no request is raised, and a pending request or armed pair is dropped. Re-enabling with a steady pin produces no edge.
- R9: After reset all stamps, flags, overrun bits, interrupts and requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | CNT_W | Free-running counter value |
| cap_in | input | NUM_CH | Asynchronous capture pins |
| cap_en | input | NUM_CH | Per-channel capture enable |
| cap_cfg | input | NUM_CH*9 | Per-channel config: bit 0 rising irq enable, bits 2:1 DMA mode, bit 8 falling irq enable |
| rise_first | input | NUM_CH | Pair order in both-edges DMA mode |
| rise_clr | input | NUM_CH | Clear strobe for rising flag and overrun |
| fall_clr | input | NUM_CH | Clear strobe for falling flag and overrun |
| dma_ack | input | NUM_CH | DMA acknowledge, one cycle per word |
| rise_data | output | NUM_CH*CNT_W | Rising-edge stamps |
| fall_data | output | NUM_CH*CNT_W | Falling-edge stamps |
| rise_flag | output | NUM_CH | Rising capture pending |
| fall_flag | output | NUM_CH | Falling capture pending |
| rise_ovr | output | NUM_CH | Sticky rising overrun |
| fall_ovr | output | NUM_CH | Sticky falling overrun |
| irq | output | NUM_CH | Per-channel interrupt |
| dma_req | output | NUM_CH | DMA request |
| dma_data | output | NUM_CH*CNT_W | Word offered with the request |

## Verification
The assertions assume that the DMA engine raises acknowledge only for one cycle per accepted word. They also assume that the configuration word and the rising-first control are changed only while the channel is disabled. The bench follows both rules: it reprograms a channel only with the enable low, and it pulses acknowledge once per observed request. The assertions also assume that the pin stays put for at least three cycles between transitions. The bench holds the pin for four cycles after every transition, so each edge passes the synchronizer on its own.

// File: rtl/cap_pkg.sv
package cap_pkg;

    // Per-channel configuration word layout.
    localparam int CFG_W = 9;

    typedef enum logic [1:0] {
        XFER_OFF  = 2'd0,
        XFER_RISE = 2'd1,
        XFER_FALL = 2'd2,
        XFER_BOTH = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_FIRST,
        ST_SECOND
    } xfer_state_e;

    // Packed view of the configuration word, MSB first.
    typedef struct packed {
        logic       fall_ie;   // bit 8
        logic [4:0] rsvd;      // bits 7:3
        xfer_mode_e mode;      // bits 2:1
        logic       rise_ie;   // bit 0
    } cap_cfg_t;

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic en_i,
    output logic rise_ev_o,
    output logic fall_ev_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // The previous-level flop keeps tracking while disabled,
    // so re-enabling never produces a stale edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            last_q <= synced;
        end
    end

    assign rise_ev_o = en_i &  synced & ~last_q;
    assign fall_ev_o = en_i & ~synced &  last_q;

endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] data_o,
    output logic             flag_o,
    output logic             ovr_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (ev_i) begin
            data_o <= cnt_i;
        end
    end

    // A clear and an edge in the same cycle: the edge keeps the flag,
    // the clear still removes the overrun.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (clr_i) begin
            flag_o <= ev_i;
            ovr_o  <= 1'b0;
        end else if (ev_i) begin
            flag_o <= 1'b1;
            if (flag_o) begin
                ovr_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cap_xfer_fsm.sv
module cap_xfer_fsm
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  xfer_mode_e       mode_i,
    input  logic             rise_first_i,
    input  logic             rise_ev_i,
    input  logic             fall_ev_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] rise_q_i,
    input  logic [CNT_W-1:0] fall_q_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [CNT_W-1:0] data_o
);

    xfer_state_e      state_q, state_d;
    logic             armed_q;
    logic [CNT_W-1:0] word_a_q, word_b_q;

    logic open_ev, close_ev, single_go, pair_go;

    assign open_ev   = rise_first_i ? rise_ev_i : fall_ev_i;
    assign close_ev  = rise_first_i ? fall_ev_i : rise_ev_i;
    assign single_go = ((mode_i == XFER_RISE) & rise_ev_i) |
                       ((mode_i == XFER_FALL) & fall_ev_i);
    assign pair_go   = (mode_i == XFER_BOTH) & armed_q & close_ev;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (single_go) begin
                    state_d = ST_SINGLE;
                end else if (pair_go) begin
                    state_d = ST_FIRST;
                end
            end
            ST_SINGLE: if (ack_i) state_d = ST_IDLE;
            ST_FIRST:  if (ack_i) state_d = ST_SECOND;
            ST_SECOND: if (ack_i) state_d = ST_IDLE;
        endcase
        if (!en_i) begin
            state_d = ST_IDLE;
        end
    end

    // Pair arming: opening edge arms, launch or disable disarms.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!en_i || (mode_i != XFER_BOTH)) begin
            armed_q <= 1'b0;
        end else if ((state_q == ST_IDLE) && pair_go) begin
            armed_q <= 1'b0;
        end else if (open_ev) begin
            armed_q <= 1'b1;
        end
    end

    // Words are frozen at launch so later edges cannot disturb them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_a_q <= '0;
            word_b_q <= '0;
        end else if (state_q == ST_IDLE) begin
            if (state_d == ST_SINGLE) begin
                word_a_q <= cnt_i;
            end else if (state_d == ST_FIRST) begin
                word_a_q <= rise_first_i ? rise_q_i : fall_q_i;
                word_b_q <= cnt_i;
            end
        end
    end

    // Output logic.
    always_comb begin
        req_o  = 1'b0;
        data_o = word_a_q;
        unique case (state_q)
            ST_IDLE:   req_o = 1'b0;
            ST_SINGLE: req_o = 1'b1;
            ST_FIRST:  req_o = 1'b1;
            ST_SECOND: begin
                req_o  = 1'b1;
                data_o = word_b_q;
            end
        endcase
    end

endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          cnt_in,
    input  logic [NUM_CH-1:0]         cap_in,
    input  logic [NUM_CH-1:0]         cap_en,
    input  logic [NUM_CH*CFG_W-1:0]   cap_cfg,
    input  logic [NUM_CH-1:0]         rise_first,
    input  logic [NUM_CH-1:0]         rise_clr,
    input  logic [NUM_CH-1:0]         fall_clr,
    input  logic [NUM_CH-1:0]         dma_ack,
    output logic [NUM_CH*CNT_W-1:0]   rise_data,
    output logic [NUM_CH*CNT_W-1:0]   fall_data,
    output logic [NUM_CH-1:0]         rise_flag,
    output logic [NUM_CH-1:0]         fall_flag,
    output logic [NUM_CH-1:0]         rise_ovr,
    output logic [NUM_CH-1:0]         fall_ovr,
    output logic [NUM_CH-1:0]         irq,
    output logic [NUM_CH-1:0]         dma_req,
    output logic [NUM_CH*CNT_W-1:0]   dma_data
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cap_cfg_t         cfg_w;
        logic             rise_ev, fall_ev;
        logic [CNT_W-1:0] rise_q, fall_q, xfer_word;
        logic             unused_rsvd;

        assign cfg_w       = cap_cfg_t'(cap_cfg[g*CFG_W +: CFG_W]);
        assign unused_rsvd = ^cfg_w.rsvd;

        cap_edge_detect #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (cap_in[g]),
            .en_i     (cap_en[g]),
            .rise_ev_o(rise_ev),
            .fall_ev_o(fall_ev)
        );

        cap_latch #(.CNT_W(CNT_W)) u_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_i  (rise_ev),
            .clr_i (rise_clr[g]),
            .cnt_i (cnt_in),
            .data_o(rise_q),
            .flag_o(rise_flag[g]),
            .ovr_o (rise_ovr[g])
        );

        cap_latch #(.CNT_W(CNT_W)) u_fall (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_i  (fall_ev),
            .clr_i (fall_clr[g]),
            .cnt_i (cnt_in),
            .data_o(fall_q),
            .flag_o(fall_flag[g]),
            .ovr_o (fall_ovr[g])
        );

        cap_xfer_fsm #(.CNT_W(CNT_W)) u_xfer (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (cap_en[g]),
            .mode_i      (cfg_w.mode),
            .rise_first_i(rise_first[g]),
            .rise_ev_i   (rise_ev),
            .fall_ev_i   (fall_ev),
            .cnt_i       (cnt_in),
            .rise_q_i    (rise_q),
            .fall_q_i    (fall_q),
            .ack_i       (dma_ack[g]),
            .req_o       (dma_req[g]),
            .data_o      (xfer_word)
        );

        assign rise_data[g*CNT_W +: CNT_W] = rise_q;
        assign fall_data[g*CNT_W +: CNT_W] = fall_q;
        assign dma_data[g*CNT_W +: CNT_W]  = xfer_word;
        assign irq[g] = (rise_flag[g] & cfg_w.rise_ie) |
                        (fall_flag[g] & cfg_w.fall_ie);
    end

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       cap_en,
    input logic [NUM_CH-1:0]       dma_ack,
    input logic [NUM_CH*CNT_W-1:0] rise_data,
    input logic [NUM_CH*CNT_W-1:0] fall_data,
    input logic [NUM_CH-1:0]       rise_flag,
    input logic [NUM_CH-1:0]       fall_flag,
    input logic [NUM_CH-1:0]       rise_ovr,
    input logic [NUM_CH-1:0]       fall_ovr,
    input logic [NUM_CH-1:0]       irq,
    input logic [NUM_CH-1:0]       dma_req,
    input logic [NUM_CH*CNT_W-1:0] dma_data
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_stamp_needs_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(rise_data[g*CNT_W +: CNT_W]) |-> rise_flag[g]);

        assert_fall_stamp_needs_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(fall_data[g*CNT_W +: CNT_W]) |-> fall_flag[g]);

        assert_ovr_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rise_ovr[g]) |-> rise_flag[g]) and ($rose(fall_ovr[g]) |-> fall_flag[g]));

        assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> (rise_flag[g] | fall_flag[g]));

        assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_req[g] && !dma_ack[g] && cap_en[g]) |=>
                (dma_req[g] && $stable(dma_data[g*CNT_W +: CNT_W])));

        assert_off_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_en[g] |=> (!$rose(rise_flag[g]) && !$rose(fall_flag[g])));

        assert_off_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_en[g] |=> !dma_req[g]);
    end

endmodule

bind cap_unit cap_unit_chk #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .dma_ack  (dma_ack),
    .rise_data(rise_data),
    .fall_data(fall_data),
    .rise_flag(rise_flag),
    .fall_flag(fall_flag),
    .rise_ovr (rise_ovr),
    .fall_ovr (fall_ovr),
    .irq      (irq),
    .dma_req  (dma_req),
    .dma_data (dma_data)
);

// File: tb/cap_unit_tb.sv
module cap_unit_tb;
    import cap_pkg::*;

    localparam int N  = 2;
    localparam int CW = 16;
    localparam int FW = CFG_W;

    // Vector: [8:7] mode, [6] rise_first, [5:4] word count,
    // [3:2] first word index, [1:0] second word index.
    // Index: 0 = rise1, 1 = fall1, 2 = rise2, 3 = fall2.
    localparam logic [8:0] VEC_TAB [6] = '{
        {2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
        {2'd1, 1'b0, 2'd1, 2'd0, 2'd0},
        {2'd2, 1'b0, 2'd1, 2'd1, 2'd0},
        {2'd3, 1'b1, 2'd2, 2'd0, 2'd1},
        {2'd3, 1'b0, 2'd2, 2'd1, 2'd2},
        {2'd1, 1'b1, 2'd1, 2'd0, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [N-1:0] cap_in = '0, cap_en = '0, rise_first = '0;
    logic [N-1:0] rise_clr = '0, fall_clr = '0, dma_ack = '0;
    logic [N*FW-1:0] cap_cfg = '0;
    logic [N*CW-1:0] rise_data, fall_data, dma_data;
    logic [N-1:0] rise_flag, fall_flag, rise_ovr, fall_ovr, irq, dma_req;

    int n_tests = 0;
    int n_fail  = 0;

    cap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt), .cap_in(cap_in),
        .cap_en(cap_en), .cap_cfg(cap_cfg), .rise_first(rise_first),
        .rise_clr(rise_clr), .fall_clr(fall_clr), .dma_ack(dma_ack),
        .rise_data(rise_data), .fall_data(fall_data),
        .rise_flag(rise_flag), .fall_flag(fall_flag),
        .rise_ovr(rise_ovr), .fall_ovr(fall_ovr), .irq(irq),
        .dma_req(dma_req), .dma_data(dma_data)
    );

    always #2 clk = ~clk;
    always @(negedge clk) cnt <= cnt + 16'd1;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [FW-1:0] mk_cfg(input logic rie, input logic fie,
                                             input logic [1:0] mode);
        return {fie, 5'b0, mode, rie};
    endfunction

    // Drive the pin just after a falling edge; return the expected stamp.
    task automatic move_pin(input logic v, output logic [CW-1:0] stamp);
        step();
        cap_in[0] = v;
        stamp = cnt + 16'd2;
    endtask

    task automatic edge_settle(input logic v, output logic [CW-1:0] stamp);
        move_pin(v, stamp);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        step();
        rise_clr[0] = 1'b1;
        fall_clr[0] = 1'b1;
        step();
        rise_clr[0] = 1'b0;
        fall_clr[0] = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [CW-1:0] s, s2, keep;
        logic [CW-1:0] ev [4];

        // R9: reset state
        repeat (4) step();
        chk("R9", "flags", {rise_flag, fall_flag, rise_ovr, fall_ovr}, '0);
        chk("R9", "stamps", {rise_data, fall_data} == '0, 1);
        chk("R9", "irq/req", {irq, dma_req}, '0);
        rst_n = 1'b1;

        // R1 / R2 / R4: latency, stamp value, interrupt gating
        cap_en[0] = 1'b1;
        cap_cfg[FW-1:0] = mk_cfg(1'b1, 1'b0, 2'd0);
        move_pin(1'b1, s);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "flag after two edges", rise_flag[0], 0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "flag after three edges", rise_flag[0], 1);
        chk("R1", "rising stamp", rise_data[CW-1:0], s);
        chk("R4", "irq from rising flag", irq[0], 1);
        edge_settle(1'b0, s2);
        chk("R2", "falling stamp", fall_data[CW-1:0], s2);
        chk("R2", "falling flag", fall_flag[0], 1);
        chk("R2", "other channel idle", {rise_flag[1], fall_flag[1]}, 0);
        step();
        rise_clr[0] = 1'b1;
        step();
        rise_clr[0] = 1'b0;
        chk("R4", "falling flag masked", irq[0], 0);
        cap_cfg[FW-1:0] = mk_cfg(1'b1, 1'b1, 2'd0);
        step();
        chk("R4", "falling flag unmasked", irq[0], 1);
        clear_all();

        // R3: overrun set and cleared
        edge_settle(1'b1, s);
        chk("R3", "no overrun on first edge", rise_ovr[0], 0);
        edge_settle(1'b0, s);
        edge_settle(1'b1, s);
        chk("R3", "overrun on second edge", rise_ovr[0], 1);
        chk("R3", "stamp overwritten", rise_data[CW-1:0], s);
        clear_all();
        chk("R3", "clear removes flag+ovr", {rise_flag[0], rise_ovr[0]}, 0);

        // R3: edge coinciding with clear
        edge_settle(1'b0, s);
        edge_settle(1'b1, s);
        edge_settle(1'b0, s);
        move_pin(1'b1, s);
        repeat (2) @(posedge clk);
        step();
        rise_clr[0] = 1'b1;
        step();
        rise_clr[0] = 1'b0;
        chk("R3", "edge beats clear", {rise_flag[0], rise_ovr[0]}, 2'b10);
        chk("R3", "stamp on clear cycle", rise_data[CW-1:0], s);
        clear_all();

        // R8: disabled channel ignores edges
        keep = rise_data[CW-1:0];
        cap_en[0] = 1'b0;
        cap_cfg[FW-1:0] = mk_cfg(1'b1, 1'b1, 2'd1);
        edge_settle(1'b0, s);
        edge_settle(1'b1, s);
        chk("R8", "flags while disabled", {rise_flag[0], fall_flag[0]}, 0);
        chk("R8", "stamp kept while disabled", rise_data[CW-1:0], keep);
        chk("R8", "no request while disabled", dma_req[0], 0);
        cap_en[0] = 1'b1;
        repeat (4) step();
        chk("R8", "no edge on re-enable", {rise_flag[0], fall_flag[0]}, 0);
        edge_settle(1'b0, s);
        chk("R6", "falling edge ignored in rising mode", dma_req[0], 0);
        edge_settle(1'b1, s);
        chk("R6", "rising request", dma_req[0], 1);
        chk("R6", "rising request data", dma_data[CW-1:0], s);
        cap_en[0] = 1'b0;
        step();
        chk("R8", "pending request dropped", dma_req[0], 0);
        edge_settle(1'b0, s);

        // R5 / R6 / R7: table of DMA configurations
        for (int v = 0; v < 6; v++) begin
            logic [1:0] mode;
            logic [1:0] nw;
            string tag;
            mode = VEC_TAB[v][8:7];
            nw   = VEC_TAB[v][5:4];
            tag  = (mode == 2'd3) ? "R7" : ((mode == 2'd0) ? "R5" : "R6");
            cap_en[0] = 1'b0;
            step();
            cap_cfg[FW-1:0] = mk_cfg(1'b0, 1'b0, mode);
            rise_first[0] = VEC_TAB[v][6];
            cap_en[0] = 1'b1;
            clear_all();
            edge_settle(1'b1, ev[0]);
            edge_settle(1'b0, ev[1]);
            edge_settle(1'b1, ev[2]);
            edge_settle(1'b0, ev[3]);
            chk("R3", "latest rising stamp", rise_data[CW-1:0], ev[2]);
            chk("R3", "latest falling stamp", fall_data[CW-1:0], ev[3]);
            chk("R3", "both overruns", {rise_ovr[0], fall_ovr[0]}, 2'b11);
            for (int w = 0; w < int'(nw); w++) begin
                logic got;
                logic [1:0] sel;
                sel = (w == 0) ? VEC_TAB[v][3:2] : VEC_TAB[v][1:0];
                got = 1'b0;
                for (int t = 0; t < 10 && !got; t++) begin
                    @(negedge clk);
                    if (dma_req[0]) got = 1'b1;
                end
                chk(tag, "request present", got, 1);
                chk(tag, "word order/data", dma_data[CW-1:0], ev[sel]);
                #1 dma_ack[0] = 1'b1;
                step();
                dma_ack[0] = 1'b0;
            end
            repeat (3) step();
            chk("R5", "no extra request", dma_req[0], 0);
        end

        chk("R2", "channel 1 untouched", {rise_flag[1], fall_flag[1], dma_req[1]}, 0);
        finish_run();
    end

endmodule